// File: doc/BRIEF.md
# Power-Manager Control Register Slave on a Two-Wire Serial Bus

This block lets a host processor read and write a seven-entry control register file over a two-wire serial bus. The bus clock and data lines arrive as inputs. Data is driven by an open-drain output-enable: when `sda_oe` is 1, the line is pulled low. The block answers only to the fixed 7-bit device address 1101000. Its register pointer advances by one after every data byte, so a long transfer walks through consecutive registers.

Every register field is also presented as a parallel output. The regulator controls of the power manager read these outputs directly: voltage codes for two buck converters and two linear regulators, the converter options, the rail enables, the power-good delay selection and the slew-rate selections.

A read can name its starting register. To do that, the host sends a write frame that carries only the register index, then a repeated START and a read frame. A read can also start directly with a read frame, and then it continues from wherever the pointer was left.

Top module: `pmu_i2c_regfile`

## Requirements
- R1: After reset the registers hold these values: index 0 = 0x0F, index 1 = 0x14, index 2 = 0x0C, index 3 = 0x12, index 4 = 0x0F, index 5 = 0x2F and index 6 = 0x12. The parallel outputs show the same values.
- R2: The first byte after a START is the device address followed by a direction bit (0 = write, 1 = read). If the address bits equal 1101000, the slave acknowledges by pulling SDA low during the ninth clock. If they do not match, the slave leaves SDA released and ignores every later byte until the next START.
- R3: In a write frame, the byte after the address is the register index and loads the pointer. Each following byte is stored at the pointer, and the pointer then increments. The slave acknowledges every byte of the frame.
- R4: A write frame carrying only a register index, followed by a repeated START and a read frame, returns data starting at that index. Consecutive bytes come from consecutive indices.
- R5: A read frame sent without a preceding index returns data from the current pointer. The pointer is the value left by the previous access and advances once per byte returned.
- R6: When the host answers a returned byte with NACK (SDA high in the ninth clock), the slave stops driving SDA. It drives nothing until the next START.
- R7: Reserved bits ignore writes and read as 0. The reserved bits are: bit 7 of indices 0, 1, 4 and 5; bits 7:6 of indices 2 and 3; bits 7 and 3 of index 6.
- R8: Indices above 6 acknowledge written bytes but store nothing, and they read back as 0x00.
- R9: The parallel outputs present the register fields as follows:
  - Index 5: bit 6 is `if_en`, bits 5:4 are `pg_delay`, and bits 3:0 are `rail_en` (bit 3 second regulator, bit 2 first regulator, bit 1 second buck, bit 0 first buck).
  - Index 6: bits 6:4 are `buck2_slew` and bits 2:0 are `buck1_slew`.
  - Index 4: bits 6:0 are `conv_cfg`.
  - Indices 0 to 3: the voltage codes, in the order buck 1, buck 2, regulator 1, regulator 2.
- R10: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START in the middle of a frame restarts address decoding. The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| buck1_code | output | 7 | Buck 1 voltage code (index 0) |
| buck2_code | output | 7 | Buck 2 voltage code (index 1) |
| ldo1_code | output | 6 | Regulator 1 voltage code (index 2) |
| ldo2_code | output | 6 | Regulator 2 voltage code (index 3) |
| conv_cfg | output | 7 | Converter option bits (index 4) |
| if_en | output | 1 | Interface enable bit (index 5, bit 6) |
| pg_delay | output | 2 | Power-good delay select (index 5, bits 5:4) |
| rail_en | output | 4 | Rail enables (index 5, bits 3:0) |
| buck2_slew | output | 3 | Buck 2 slew select (index 6, bits 6:4) |
| buck1_slew | output | 3 | Buck 1 slew select (index 6, bits 2:0) |

## Verification
The assertions assume a well-behaved host, in four ways:
- Each SCL phase lasts several system clocks, so every edge passes through the synchronizer before the next edge arrives.
- The host moves SDA only while SCL is low, except when it deliberately signals a START or STOP.
- The host never signals START or STOP during the slave's acknowledge clock.
- The host never drives a STOP while the slave is shifting out a zero bit.

The bench drives the bus with quarter-bit phases of ten system clocks. It changes SDA only in the low phase, and it builds SDA as the wired-AND of the host level and the slave's pull-down, so these assumptions hold throughout the stimulus.

// File: rtl/pmu_i2c_regfile.sv
module pmu_i2c_regfile #(
  parameter logic [6:0] DEV_ADDR   = 7'b1101000,
  parameter logic [6:0] BUCK1_INIT = 7'h0F,
  parameter logic [6:0] BUCK2_INIT = 7'h14,
  parameter logic [5:0] LDO1_INIT  = 6'h0C,
  parameter logic [5:0] LDO2_INIT  = 6'h12,
  parameter logic [7:0] CONV_INIT  = 8'h0F,
  parameter logic [7:0] SYS_INIT   = 8'h2F,
  parameter logic [7:0] SLEW_INIT  = 8'h12
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [6:0] buck1_code,
  output logic [6:0] buck2_code,
  output logic [5:0] ldo1_code,
  output logic [5:0] ldo2_code,
  output logic [6:0] conv_cfg,
  output logic       if_en,
  output logic [1:0] pg_delay,
  output logic [3:0] rail_en,
  output logic [2:0] buck2_slew,
  output logic [2:0] buck1_slew
);
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_HACK} st_t;
  typedef enum logic [1:0] {P_DEV, P_REG, P_DAT} ph_t;

  logic [2:0] scl_p, sda_p;
  st_t        state;
  ph_t        phase;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sh;
  logic [6:0] tx_sh;
  logic [7:0] ptr;
  logic       rd_mode;
  logic [7:0] rd_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire scl_s    = scl_p[1];
  wire sda_s    = sda_p[1];
  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire start_c  = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_c   = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];

  always_comb
    case (ptr)
      8'h00:   rd_byte = {1'b0, buck1_code};
      8'h01:   rd_byte = {1'b0, buck2_code};
      8'h02:   rd_byte = {2'b00, ldo1_code};
      8'h03:   rd_byte = {2'b00, ldo2_code};
      8'h04:   rd_byte = {1'b0, conv_cfg};
      8'h05:   rd_byte = {1'b0, if_en, pg_delay, rail_en};
      8'h06:   rd_byte = {1'b0, buck2_slew, 1'b0, buck1_slew};
      default: rd_byte = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= S_IDLE;
      phase      <= P_DEV;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      ptr        <= '0;
      rd_mode    <= 1'b0;
      sda_oe     <= 1'b0;
      buck1_code <= BUCK1_INIT;
      buck2_code <= BUCK2_INIT;
      ldo1_code  <= LDO1_INIT;
      ldo2_code  <= LDO2_INIT;
      conv_cfg   <= CONV_INIT[6:0];
      if_en      <= SYS_INIT[6];
      pg_delay   <= SYS_INIT[5:4];
      rail_en    <= SYS_INIT[3:0];
      buck2_slew <= SLEW_INIT[6:4];
      buck1_slew <= SLEW_INIT[2:0];
    end else if (start_c) begin
      state   <= S_RX;
      phase   <= P_DEV;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_RX:
          if (scl_rise && bit_cnt < 4'd8) begin
            rx_sh   <= {rx_sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            bit_cnt <= '0;
            case (phase)
              P_DEV:
                if (rx_sh[7:1] == DEV_ADDR) begin
                  rd_mode <= rx_sh[0];
                  phase   <= P_REG;
                  state   <= S_ACK;
                  sda_oe  <= 1'b1;
                end else begin
                  state <= S_IDLE;
                end
              P_REG: begin
                ptr    <= rx_sh;
                phase  <= P_DAT;
                state  <= S_ACK;
                sda_oe <= 1'b1;
              end
              default: begin
                case (ptr)
                  8'h00: buck1_code <= rx_sh[6:0];
                  8'h01: buck2_code <= rx_sh[6:0];
                  8'h02: ldo1_code  <= rx_sh[5:0];
                  8'h03: ldo2_code  <= rx_sh[5:0];
                  8'h04: conv_cfg   <= rx_sh[6:0];
                  8'h05: begin
                    if_en    <= rx_sh[6];
                    pg_delay <= rx_sh[5:4];
                    rail_en  <= rx_sh[3:0];
                  end
                  8'h06: begin
                    buck2_slew <= rx_sh[6:4];
                    buck1_slew <= rx_sh[2:0];
                  end
                  default: ;
                endcase
                ptr    <= ptr + 8'd1;
                state  <= S_ACK;
                sda_oe <= 1'b1;
              end
            endcase
          end
        S_ACK:
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rd_mode) begin
              tx_sh  <= rd_byte[6:0];
              sda_oe <= ~rd_byte[7];
              ptr    <= ptr + 8'd1;
              state  <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_RX;
            end
          end
        S_TX:
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= S_HACK;
            end else begin
              sda_oe <= ~tx_sh[6];
              tx_sh  <= {tx_sh[5:0], 1'b0};
            end
          end
        S_HACK:
          if (scl_rise && sda_s) begin
            state <= S_IDLE;
          end else if (scl_fall) begin
            bit_cnt <= '0;
            tx_sh   <= rd_byte[6:0];
            sda_oe  <= ~rd_byte[7];
            ptr     <= ptr + 8'd1;
            state   <= S_TX;
          end
        default: ;
      endcase
    end

  assert_drive_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);

  assert_ack_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACK && scl_s) |-> sda_oe);

  assert_regs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_RX) |=> ($stable(rail_en) && $stable(buck1_code) && $stable(buck2_slew)));
endmodule

// File: tb/tb_pmu_i2c_regfile.sv
`timescale 1ns/1ps
module tb_pmu_i2c_regfile;
  localparam int QTR = 10;
  localparam logic [7:0] AW = 8'hD0;
  localparam logic [7:0] AR = 8'hD1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_oe;
  logic [6:0] buck1_code, buck2_code, conv_cfg;
  logic [5:0] ldo1_code, ldo2_code;
  logic if_en;
  logic [1:0] pg_delay;
  logic [3:0] rail_en;
  logic [2:0] buck2_slew, buck1_slew;
  wire sda_bus = host_sda & ~sda_oe;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pmu_i2c_regfile dut (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .buck1_code(buck1_code), .buck2_code(buck2_code), .ldo1_code(ldo1_code),
    .ldo2_code(ldo2_code), .conv_cfg(conv_cfg), .if_en(if_en), .pg_delay(pg_delay),
    .rail_en(rail_en), .buck2_slew(buck2_slew), .buck1_slew(buck1_slew));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (QTR) @(posedge clk);
    #2;
  endtask

  task automatic bus_start();
    host_sda = 1'b1; qw();
    host_scl = 1'b1; qw();
    host_sda = 1'b0; qw();
    host_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; qw();
    host_scl = 1'b1; qw();
    host_sda = 1'b1; qw();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; qw();
      host_scl = 1'b1; qw(); qw();
      host_scl = 1'b0;
    end
    host_sda = 1'b1; qw();
    host_scl = 1'b1; qw();
    ack = ~sda_bus; qw();
    host_scl = 1'b0; qw();
  endtask

  task automatic rbyte(input logic last, output logic [7:0] d);
    host_sda = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      qw();
      host_scl = 1'b1; qw();
      d = {d[6:0], sda_bus}; qw();
      host_scl = 1'b0;
    end
    host_sda = last; qw();
    host_scl = 1'b1; qw(); qw();
    host_scl = 1'b0; qw();
    host_sda = 1'b1;
  endtask

  task automatic wr_frame(input string tag, input logic [7:0] idx, input logic [7:0] d [],
                          input int n);
    logic a;
    bus_start();
    wbyte(AW, a); chk({tag, " addr ack"}, {7'd0, a}, 8'd1);
    wbyte(idx, a); chk({tag, " index ack"}, {7'd0, a}, 8'd1);
    for (int i = 0; i < n; i++) begin
      wbyte(d[i], a); chk({tag, " data ack"}, {7'd0, a}, 8'd1);
    end
    bus_stop();
  endtask

  task automatic rd_at(input string tag, input logic [7:0] idx, input logic [7:0] exp [],
                       input int n);
    logic a;
    logic [7:0] d;
    bus_start();
    wbyte(AW, a); chk({tag, " addr ack"}, {7'd0, a}, 8'd1);
    wbyte(idx, a); chk({tag, " index ack"}, {7'd0, a}, 8'd1);
    bus_start();
    wbyte(AR, a); chk({tag, " read addr ack"}, {7'd0, a}, 8'd1);
    for (int i = 0; i < n; i++) begin
      rbyte(i == n - 1, d); chk({tag, " data"}, d, exp[i]);
    end
    bus_stop();
  endtask

  task automatic rd_cur(input string tag, input logic [7:0] exp [], input int n);
    logic a;
    logic [7:0] d;
    bus_start();
    wbyte(AR, a); chk({tag, " read addr ack"}, {7'd0, a}, 8'd1);
    for (int i = 0; i < n; i++) begin
      rbyte(i == n - 1, d); chk({tag, " data"}, d, exp[i]);
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 reset buck1", {1'b0, buck1_code}, 8'h0F);
    chk("R1 reset ldo2", {2'b0, ldo2_code}, 8'h12);
    chk("R1 R9 reset sys outputs", {1'b0, if_en, pg_delay, rail_en}, 8'h2F);
    chk("R1 R9 reset slew outputs", {1'b0, buck2_slew, 1'b0, buck1_slew}, 8'h12);
    chk("R1 R9 reset conv", {1'b0, conv_cfg}, 8'h0F);
    rd_at("R1 R4 reset readback", 8'h00, '{8'h0F, 8'h14, 8'h0C, 8'h12, 8'h0F, 8'h2F, 8'h12}, 7);
    chk("R6 released after host NACK", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic t_write_burst();
    wr_frame("R3 burst 4..6", 8'h04, '{8'hFF, 8'hFF, 8'hFF}, 3);
    chk("R9 R7 conv_cfg", {1'b0, conv_cfg}, 8'h7F);
    chk("R9 if_en", {7'd0, if_en}, 8'd1);
    chk("R9 pg_delay", {6'd0, pg_delay}, 8'd3);
    chk("R9 rail_en", {4'd0, rail_en}, 8'h0F);
    chk("R9 buck2_slew", {5'd0, buck2_slew}, 8'd7);
    chk("R9 buck1_slew", {5'd0, buck1_slew}, 8'd7);
    rd_at("R7 reserved read zero 4..6", 8'h04, '{8'h7F, 8'h7F, 8'h77}, 3);
    wr_frame("R3 burst 0..3", 8'h00, '{8'hFF, 8'hAA, 8'hFF, 8'h55}, 4);
    chk("R9 buck2_code", {1'b0, buck2_code}, 8'h2A);
    chk("R9 ldo1_code", {2'b0, ldo1_code}, 8'h3F);
    rd_at("R7 R3 readback 0..3", 8'h00, '{8'h7F, 8'h2A, 8'h3F, 8'h15}, 4);
  endtask

  task automatic t_no_index();
    logic [7:0] none [];
    none = new[1];
    wr_frame("R5 pointer set", 8'h02, none, 0);
    rd_cur("R5 current read", '{8'h3F, 8'h15}, 2);
    rd_cur("R5 pointer continues", '{8'h7F}, 1);
  endtask

  task automatic t_beyond();
    wr_frame("R8 write past end", 8'h06, '{8'h00, 8'hAA}, 2);
    chk("R8 slew cleared", {1'b0, buck2_slew, 1'b0, buck1_slew}, 8'h00);
    wr_frame("R8 write unmapped", 8'h09, '{8'hFF}, 1);
    rd_at("R8 unmapped reads zero", 8'h06, '{8'h00, 8'h00, 8'h00}, 3);
  endtask

  task automatic t_foreign();
    logic a;
    bus_start();
    wbyte(8'hA0, a); chk("R2 foreign addr nack", {7'd0, a}, 8'd0);
    wbyte(AW, a); chk("R2 ignored until start", {7'd0, a}, 8'd0);
    wbyte(8'h05, a); chk("R2 ignored index", {7'd0, a}, 8'd0);
    wbyte(8'h00, a); chk("R2 ignored data", {7'd0, a}, 8'd0);
    bus_stop();
    chk("R2 rails untouched", {4'd0, rail_en}, 8'h0F);
    bus_start();
    wbyte(8'hD2, a); chk("R2 near-miss addr nack", {7'd0, a}, 8'd0);
    bus_stop();
    rd_at("R2 matched after new start", 8'h05, '{8'h7F}, 1);
  endtask

  task automatic t_restart();
    logic a;
    bus_start();
    wbyte(AW, a);
    wbyte(8'h01, a);
    bus_start();
    wbyte(AW, a); chk("R10 restart addr ack", {7'd0, a}, 8'd1);
    wbyte(8'h00, a);
    wbyte(8'h33, a); chk("R10 data ack", {7'd0, a}, 8'd1);
    bus_stop();
    chk("R10 restart stored at new index", {1'b0, buck1_code}, 8'h33);
    chk("R10 old index untouched", {1'b0, buck2_code}, 8'h2A);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    qw();
    t_reset();
    t_write_burst();
    t_no_index();
    t_beyond();
    t_foreign();
    t_restart();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule